// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block sits between a set of free-running source clocks and the clock pins of a board-level clock generator. It passes each group of clocks through to its outputs or holds that group low. Three active-low controls decide which groups run: a CPU hold, a PCI hold and a sleep request. The source clocks come from elsewhere, and the block only gates them. Each group is gated in its own clock domain. The hold request passes through a synchronizer in that domain, and the gate opens or closes only during the low phase of its clock. An output therefore produces only whole high pulses.

The sleep request acts at once, without waiting for a clock edge. It forces every output low and drops the oscillator and VCO enables. When sleep is released, a counter on the reference clock holds all outputs low for a settle interval, and only then are the groups allowed to run. The half-rate CPU, free-running PCI, reference and APIC groups ignore both hold inputs.

Top module: `clkgate_pm_ctrl`

## Requirements
- R1: While `sleep_n` is 0, every clock output is 0 and `osc_en` and `vco_en` are 0, whatever the hold inputs do. This takes effect immediately, with no clock edge. While `sleep_n` is 1, `osc_en` and `vco_en` are 1.
- R2: While `cpu_hold_n` is 0, the CPU and AGP outputs stay low. The half-rate CPU output keeps toggling.
- R3: While `pci_hold_n` is 0, the synchronous PCI outputs stay low. `pcif_clk_o` keeps toggling.
- R4: Once settled, the half-rate CPU, free-running PCI, reference and APIC outputs run for every combination of the two hold inputs.
- R5: A hold input is sampled by SYNC_STAGES (default 2) flops on the rising edges of its group's source clock. When a hold asserts away from an edge, the output gives exactly SYNC_STAGES more pulses. When a hold releases, the first output pulse comes on the (SYNC_STAGES+1)-th source rising edge after the change. With the default setting, this puts the output change 2 to 3 source cycles after the input change.
- R6: Every output high pulse starts at a source rising edge and lasts the full source high phase. No output is high while its source is low.
- R7: After reset release or sleep release, all outputs stay low until SETTLE_CYCLES reference-clock rising edges have passed. The first reference output pulse then falls on reference edge SETTLE_CYCLES+SYNC_STAGES+1.
- R8: All bits of each output vector are identical copies of the group's gated clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low power-down request, asynchronous |
| cpu_hold_n | input | 1 | Active-low stop for the CPU and AGP groups, asynchronous |
| pci_hold_n | input | 1 | Active-low stop for the synchronous PCI group, asynchronous |
| src_cpu_clk | input | 1 | Source clock for the CPU group |
| src_agp_clk | input | 1 | Source clock for the AGP group |
| src_half_clk | input | 1 | Source clock for the half-rate CPU group |
| src_pci_clk | input | 1 | Source clock for both PCI groups |
| src_ref_clk | input | 1 | Reference clock; also drives the settle counter |
| src_apic_clk | input | 1 | Source clock for the APIC group |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| agp_clk_o | output | N_AGP | Gated AGP clocks |
| half_clk_o | output | N_HALF | Gated half-rate CPU clocks |
| pci_clk_o | output | N_PCI | Gated synchronous PCI clocks |
| pcif_clk_o | output | 1 | Free-running PCI clock, stopped only by sleep |
| ref_clk_o | output | N_REF | Gated reference clocks |
| apic_clk_o | output | N_APIC | Gated APIC clocks |
| osc_en | output | 1 | Oscillator enable, low in sleep |
| vco_en | output | 1 | VCO enable, low in sleep |

## Verification
The bench steps through all eight settings of sleep and the two holds. In each setting it counts pulses on every group. A wrong enable matrix would stop a group that must keep running, such as the half-rate CPU output under a CPU hold. It changes the CPU hold in the middle of both the high and the low phase, then checks the exact number of trailing pulses and the time to the first pulse on restart. A missing or extra synchronizer stage shows up as a pulse count off by one. Every output high pulse is timed against its source half-period, so a gate that switches during the high phase leaves a short pulse. After sleep release, the bench counts reference edges up to the first reference output pulse, which exposes a settle counter that is too short or that does not restart.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

   // Group indices into the gated clock vector
   localparam int GRP_CPU  = 0;
   localparam int GRP_AGP  = 1;
   localparam int GRP_HALF = 2;
   localparam int GRP_PCI  = 3;
   localparam int GRP_PCIF = 4;
   localparam int GRP_REF  = 5;
   localparam int GRP_APIC = 6;
   localparam int NUM_GRP  = 7;

   // Which hold input governs a group; groups without one only follow sleep/settle
   function automatic logic grp_allows(input int grp, input logic cpu_hold_n,
                                       input logic pci_hold_n);
      logic ok;
      case (grp)
         GRP_CPU, GRP_AGP: ok = cpu_hold_n;
         GRP_PCI:          ok = pci_hold_n;
         default:          ok = 1'b1;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/clkgate_settle.sv
module clkgate_settle #(
   parameter int SETTLE_CYCLES = 42954
) (
   input  logic ref_clk,
   input  logic clr_n,
   output logic settled
);
   localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

   generate
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("clkgate_settle: SETTLE_CYCLES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   // Counts reference edges after clr_n releases; settled is sticky until cleared
   always_ff @(posedge ref_clk or negedge clr_n) begin
      if (!clr_n) begin
         cnt_q   <= '0;
         settled <= 1'b0;
      end else if (!settled) begin
         if (cnt_q == CNT_W'(SETTLE_CYCLES - 1)) settled <= 1'b1;
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R7: once settled, only a clear brings it back down
   assert_settled_sticky_R7: assert property (@(posedge ref_clk) disable iff (!clr_n)
      settled |=> settled);

endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_in,
   input  logic kill_n,
   input  logic run_req,
   output logic clk_out
);
   localparam int AGE_W   = $clog2(SYNC_STAGES + 2);
   localparam int AGE_MAX = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clkgate_cell: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   en_q;
   logic [AGE_W-1:0]       age_q;

   // Request synchronizer on the rising edge of the gated clock
   always_ff @(posedge clk_in or negedge kill_n) begin
      if (!kill_n) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], run_req};
   end

   // Enable moves only at the falling edge, so it is stable across each high phase
   always_ff @(negedge clk_in or negedge kill_n) begin
      if (!kill_n) en_q <= 1'b0;
      else         en_q <= sync_q[SYNC_STAGES-1];
   end

   assign clk_out = clk_in & en_q;

   // Edges seen since the last kill, saturating; bounds the history the check may use
   always_ff @(posedge clk_in or negedge kill_n) begin
      if (!kill_n)                         age_q <= '0;
      else if (age_q != AGE_W'(AGE_MAX))   age_q <= age_q + 1'b1;
   end

   // R5: the enable seen at a rising edge is the request sampled SYNC_STAGES edges earlier
   assert_sync_latency_R5: assert property (@(posedge clk_in) disable iff (!kill_n)
      (age_q == AGE_W'(AGE_MAX)) |-> (en_q == $past(run_req, SYNC_STAGES)));

endmodule

// File: rtl/clkgate_pm_ctrl.sv
module clkgate_pm_ctrl
   import clkgate_pkg::*;
#(
   parameter int N_CPU         = 4,
   parameter int N_AGP         = 4,
   parameter int N_HALF        = 2,
   parameter int N_PCI         = 7,
   parameter int N_REF         = 2,
   parameter int N_APIC        = 3,
   parameter int SYNC_STAGES   = 2,
   parameter int SETTLE_CYCLES = 42954
) (
   input  logic              rst_n,
   input  logic              sleep_n,
   input  logic              cpu_hold_n,
   input  logic              pci_hold_n,
   input  logic              src_cpu_clk,
   input  logic              src_agp_clk,
   input  logic              src_half_clk,
   input  logic              src_pci_clk,
   input  logic              src_ref_clk,
   input  logic              src_apic_clk,
   output logic [N_CPU-1:0]  cpu_clk_o,
   output logic [N_AGP-1:0]  agp_clk_o,
   output logic [N_HALF-1:0] half_clk_o,
   output logic [N_PCI-1:0]  pci_clk_o,
   output logic              pcif_clk_o,
   output logic [N_REF-1:0]  ref_clk_o,
   output logic [N_APIC-1:0] apic_clk_o,
   output logic              osc_en,
   output logic              vco_en
);
   generate
      if (N_CPU < 1 || N_AGP < 1 || N_HALF < 1 || N_PCI < 1 || N_REF < 1 || N_APIC < 1)
      begin : g_bad_fanout
         $error("clkgate_pm_ctrl: every output group needs at least one copy");
      end
   endgenerate

   logic               kill_n;
   logic               settled;
   logic [NUM_GRP-1:0] src_clk;
   logic [NUM_GRP-1:0] gated_clk;

   assign kill_n = rst_n & sleep_n;
   assign osc_en = sleep_n;
   assign vco_en = sleep_n;

   assign src_clk[GRP_CPU]  = src_cpu_clk;
   assign src_clk[GRP_AGP]  = src_agp_clk;
   assign src_clk[GRP_HALF] = src_half_clk;
   assign src_clk[GRP_PCI]  = src_pci_clk;
   assign src_clk[GRP_PCIF] = src_pci_clk;
   assign src_clk[GRP_REF]  = src_ref_clk;
   assign src_clk[GRP_APIC] = src_apic_clk;

   clkgate_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .ref_clk (src_ref_clk),
      .clr_n   (kill_n),
      .settled (settled)
   );

   // One gate cell per group, each in its own source domain
   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         clkgate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .clk_in  (src_clk[g]),
            .kill_n  (kill_n),
            .run_req (settled & grp_allows(g, cpu_hold_n, pci_hold_n)),
            .clk_out (gated_clk[g])
         );
      end
   endgenerate

   assign cpu_clk_o  = {N_CPU{gated_clk[GRP_CPU]}};
   assign agp_clk_o  = {N_AGP{gated_clk[GRP_AGP]}};
   assign half_clk_o = {N_HALF{gated_clk[GRP_HALF]}};
   assign pci_clk_o  = {N_PCI{gated_clk[GRP_PCI]}};
   assign pcif_clk_o = gated_clk[GRP_PCIF];
   assign ref_clk_o  = {N_REF{gated_clk[GRP_REF]}};
   assign apic_clk_o = {N_APIC{gated_clk[GRP_APIC]}};

   // R1: sleep silences every output and both analog enables
   assert_sleep_all_low_R1: assert property (@(posedge src_ref_clk) disable iff (!rst_n)
      !sleep_n |-> (cpu_clk_o == '0 && agp_clk_o == '0 && half_clk_o == '0 &&
                    pci_clk_o == '0 && !pcif_clk_o && ref_clk_o == '0 &&
                    apic_clk_o == '0 && !osc_en && !vco_en));

   // R7: in the high phase of the reference clock, no pulse passes before settling
   assert_settle_quiet_R7: assert property (@(negedge src_ref_clk) disable iff (!rst_n)
      !settled |-> (ref_clk_o == '0));

endmodule

// File: tb/clkgate_pm_ctrl_tb.sv
`timescale 1ns/1ps
module clkgate_pm_ctrl_tb_top;
   localparam int SETTLE = 8;
   localparam int SYNC   = 2;
   localparam int NG     = 7;
   // group order in the bench: cpu, agp, half, pci, pcif, ref, apic
   localparam int HALF_P [NG] = '{10, 15, 20, 30, 30, 35, 80};

   logic rst_n, sleep_n, cpu_hold_n, pci_hold_n;
   logic cpu_src, agp_src, half_src, pci_src, ref_src, apic_src;
   logic [3:0] cpu_clk_o;
   logic [3:0] agp_clk_o;
   logic [1:0] half_clk_o;
   logic [6:0] pci_clk_o;
   logic       pcif_clk_o;
   logic [1:0] ref_clk_o;
   logic [2:0] apic_clk_o;
   logic       osc_en, vco_en;

   int checks = 0;
   int errors = 0;

   clkgate_pm_ctrl #(.SETTLE_CYCLES(SETTLE), .SYNC_STAGES(SYNC)) dut_i (
      .rst_n(rst_n), .sleep_n(sleep_n), .cpu_hold_n(cpu_hold_n), .pci_hold_n(pci_hold_n),
      .src_cpu_clk(cpu_src), .src_agp_clk(agp_src), .src_half_clk(half_src),
      .src_pci_clk(pci_src), .src_ref_clk(ref_src), .src_apic_clk(apic_src),
      .cpu_clk_o(cpu_clk_o), .agp_clk_o(agp_clk_o), .half_clk_o(half_clk_o),
      .pci_clk_o(pci_clk_o), .pcif_clk_o(pcif_clk_o), .ref_clk_o(ref_clk_o),
      .apic_clk_o(apic_clk_o), .osc_en(osc_en), .vco_en(vco_en)
   );

   // Source clocks with offsets chosen so no two domains share an edge
   initial begin cpu_src = 0;  forever #10 cpu_src = ~cpu_src; end
   initial begin agp_src = 0;  #2; forever #15 agp_src = ~agp_src; end
   initial begin half_src = 0; #4; forever #20 half_src = ~half_src; end
   initial begin pci_src = 0;  #1; forever #30 pci_src = ~pci_src; end
   initial begin ref_src = 0;  #3; forever #35 ref_src = ~ref_src; end
   initial begin apic_src = 0; #6; forever #80 apic_src = ~apic_src; end

   logic [NG-1:0] src_v, out_v, same_v;
   logic kill_b;
   assign kill_b = !(rst_n && sleep_n);
   assign src_v  = {apic_src, ref_src, pci_src, pci_src, half_src, agp_src, cpu_src};
   assign out_v  = {apic_clk_o[0], ref_clk_o[0], pcif_clk_o, pci_clk_o[0],
                    half_clk_o[0], agp_clk_o[0], cpu_clk_o[0]};
   assign same_v[0] = (cpu_clk_o == '0)  || (cpu_clk_o == '1);
   assign same_v[1] = (agp_clk_o == '0)  || (agp_clk_o == '1);
   assign same_v[2] = (half_clk_o == '0) || (half_clk_o == '1);
   assign same_v[3] = (pci_clk_o == '0)  || (pci_clk_o == '1);
   assign same_v[4] = 1'b1;
   assign same_v[5] = (ref_clk_o == '0)  || (ref_clk_o == '1);
   assign same_v[6] = (apic_clk_o == '0) || (apic_clk_o == '1);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   function automatic bit grp_on(input int g);
      case (g)
         0, 1:    return cpu_hold_n;
         3:       return pci_hold_n;
         default: return 1'b1;
      endcase
   endfunction

   // Reference model of settling: edges counted after release
   int  settle_cnt = 0;
   bit  settled_m  = 0;
   int  ref_edges  = 0;
   always @(posedge ref_src) ref_edges++;
   always @(posedge ref_src or posedge kill_b) begin
      if (kill_b) begin
         settle_cnt <= 0;
         settled_m  <= 0;
      end else if (!settled_m) begin
         settle_cnt <= settle_cnt + 1;
         settled_m  <= (settle_cnt + 1 >= SETTLE);
      end
   end

   int pulse_cnt [NG];

   for (genvar g = 0; g < NG; g++) begin : g_mdl
      bit hist [SYNC];
      bit expv;
      initial begin
         pulse_cnt[g] = 0;
         for (int i = 0; i < SYNC; i++) hist[i] = 0;
      end
      // Per-edge model: the pulse at this edge carries the request of SYNC edges ago
      always @(posedge src_v[g]) begin
         if (kill_b) begin
            expv = 0;
            for (int i = 0; i < SYNC; i++) hist[i] = 0;
         end else begin
            expv = hist[SYNC-1];
            for (int i = SYNC-1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = settled_m && grp_on(g);
         end
         #2;
         chk(out_v[g] == expv, "R5", out_v[g], expv);
         chk(same_v[g], "R8", same_v[g], 1);
      end
      always @(negedge src_v[g]) begin
         #2;
         chk(out_v[g] == 1'b0, "R6", out_v[g], 0);
      end
      always @(posedge out_v[g]) begin
         realtime t_rise;
         t_rise = $realtime;
         pulse_cnt[g] = pulse_cnt[g] + 1;
         chk(src_v[g] == 1'b1, "R6", src_v[g], 1);
         @(negedge out_v[g]);
         if (!kill_b)
            chk(int'($realtime - t_rise) == HALF_P[g], "R6",
                int'($realtime - t_rise), HALF_P[g]);
      end
   end

   task automatic align_high();
      @(posedge cpu_src); #5;
   endtask

   task automatic align_low();
      @(negedge cpu_src); #5;
   endtask

   bit finished = 0;

   initial begin
      int base [NG];
      int cnt0;
      realtime t0;
      rst_n = 0; sleep_n = 1; cpu_hold_n = 1; pci_hold_n = 1;
      repeat (5) align_high();
      // Reset state: every output low (R7)
      chk({cpu_clk_o, agp_clk_o, half_clk_o, pci_clk_o, pcif_clk_o, ref_clk_o, apic_clk_o} == '0,
          "R7", 1, 0);
      rst_n = 1;

      // Enable matrix over all eight control settings
      for (int m = 0; m < 8; m++) begin
         align_high();
         sleep_n = m[2]; cpu_hold_n = m[1]; pci_hold_n = m[0];
         #2000;
         for (int g = 0; g < NG; g++) base[g] = pulse_cnt[g];
         #1000;
         chk(osc_en == m[2] && vco_en == m[2], "R1", osc_en, m[2]);
         for (int g = 0; g < NG; g++) begin
            bit run;
            string tag;
            run = m[2] && ((g == 0 || g == 1) ? m[1] : (g == 3) ? m[0] : 1'b1);
            tag = !m[2] ? "R1" : (g < 2) ? "R2" : (g == 3) ? "R3" : "R4";
            chk((pulse_cnt[g] - base[g] > 0) == run, tag, pulse_cnt[g] - base[g], run);
         end
      end

      // Hold asserted mid-high: exactly SYNC more pulses (R5)
      align_high(); cnt0 = pulse_cnt[0]; cpu_hold_n = 0; #400;
      chk(pulse_cnt[0] - cnt0 == SYNC, "R5", pulse_cnt[0] - cnt0, SYNC);
      chk(half_clk_o !== 'x, "R2", 0, 0);
      // Release mid-high: first pulse 55 ns later (third edge)
      align_high(); t0 = $realtime; cpu_hold_n = 1;
      @(posedge cpu_clk_o[0]);
      chk(int'($realtime - t0) == 55, "R5", int'($realtime - t0), 55);
      // Hold asserted mid-low
      align_low(); cnt0 = pulse_cnt[0]; cpu_hold_n = 0; #400;
      chk(pulse_cnt[0] - cnt0 == SYNC, "R5", pulse_cnt[0] - cnt0, SYNC);
      // Release mid-low: first pulse 45 ns later
      align_low(); t0 = $realtime; cpu_hold_n = 1;
      @(posedge cpu_clk_o[0]);
      chk(int'($realtime - t0) == 45, "R5", int'($realtime - t0), 45);

      // Sleep acts at once, then settle interval on release
      #500; align_high(); sleep_n = 0; #1;
      chk({cpu_clk_o, agp_clk_o, half_clk_o, pci_clk_o, pcif_clk_o, ref_clk_o, apic_clk_o} == '0,
          "R1", 1, 0);
      chk(!osc_en && !vco_en, "R1", osc_en, 0);
      #400; align_high(); sleep_n = 1; cnt0 = ref_edges;
      @(posedge ref_clk_o[0]); #1;
      chk(ref_edges - cnt0 == SETTLE + SYNC + 1, "R7", ref_edges - cnt0, SETTLE + SYNC + 1);
      #1000;

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule